// File: doc/BRIEF.md
# Indexed Colour Lookup Table with Streaming Loader

This block holds a 256-entry colour table for a display controller and provides both the host-side loader and the pixel-side lookup. The host loads entries through a byte-wide port with two addresses. A write to the index address chooses the starting entry. Writes to the data address then supply colour bytes. Every three data bytes form one entry, taken in the order red, green, blue. After each complete entry the block steps to the next entry by itself, so a whole table or a contiguous range can be streamed without rewriting the index.

The pixel pipeline reads the table through a registered lookup port, which has two modes. In palette mode, used for 8-bit indexed pixels, one index selects a whole 24-bit entry. In gamma mode, used for 16-bit and 32-bit pixels, each colour channel of the incoming pixel indexes the table on its own and takes back only its own component. Each component is stored as a full 8-bit value.

Top module: `pal_lut`

## Requirements
- R1: After reset, `lk_rgb_o` is 0, the entry pointer is 0 and the component position is red. A triplet written with no prior index write therefore lands in entry 0.
- R2: A write with `wr_sel_i`=0 (index port) loads the entry pointer from `wr_data_i` and returns the component position to red.
- R3: Writes with `wr_sel_i`=1 (data port) fill red, then green, then blue. Red and green are only staged, and the addressed entry is unchanged until the blue byte is written. At that point all 24 bits are stored together as {red[23:16], green[15:8], blue[7:0]}.
- R4: After each blue write the entry pointer advances by one and wraps from 255 to 0.
- R5: Palette mode (`lk_mode_i`=0): a lookup with `lk_en_i`=1 returns the whole entry selected by `lk_pix_i[7:0]` on `lk_rgb_o` one clock later. `lk_pix_i[23:8]` has no effect.
- R6: Gamma mode (`lk_mode_i`=1): bits [23:16] of the output are the red component of the entry at `lk_pix_i[23:16]`. Bits [15:8] are the green component of the entry at `lk_pix_i[15:8]`. Bits [7:0] are the blue component of the entry at `lk_pix_i[7:0]`. The result appears one clock later.
- R7: A lookup issued in the same cycle as the blue write to the same entry returns the entry's previous contents.
- R8: An index write between the red and blue bytes discards the staged bytes. The entry that was being filled keeps its old value.
- R9: When `wr_en_i` is 0, the values on `wr_sel_i` and `wr_data_i` change neither the table, the entry pointer nor the component position.
- R10: When `lk_en_i` is 0, `lk_rgb_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 1 | Port address: 0 index, 1 data |
| wr_data_i | input | 8 | Host write byte |
| lk_en_i | input | 1 | Lookup enable |
| lk_mode_i | input | 1 | 0 palette, 1 gamma |
| lk_pix_i | input | 24 | Pixel or index to look up |
| lk_rgb_o | output | 24 | Looked-up colour |

## Verification
The entry pointer and the component position are never visible directly. They show up only as colour bytes landing in the wrong entry or the wrong channel. That damage becomes visible one clock after the first lookup of an affected entry. A slip in the component position shifts every later triplet, so a random stream of writes and lookups exposes it within a few entries. A pointer that fails to step or wrap is exposed as soon as the entry after the faulty step is read back. A wrong read-during-write ordering changes only the single lookup that collides with a blue write, so the bench creates that collision on purpose.

// File: rtl/pal_lut_pkg.sv
package pal_lut_pkg;
  localparam int unsigned NUM_CH = 3;

  typedef enum logic {
    PORT_INDEX = 1'b0,
    PORT_DATA  = 1'b1
  } port_e;

  typedef enum logic [1:0] {
    CH_RED   = 2'd0,
    CH_GREEN = 2'd1,
    CH_BLUE  = 2'd2
  } chan_e;

  typedef enum logic {
    LK_PALETTE = 1'b0,
    LK_GAMMA   = 1'b1
  } lk_mode_e;
endpackage

// File: rtl/pal_wr_seq.sv
module pal_wr_seq
  import pal_lut_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CH_W  = 8,
  localparam int unsigned ENT_W = NUM_CH * CH_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [CH_W-1:0]  wr_data_i,
  output logic [1:0]       comp_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             we_o,
  output logic [IDX_W-1:0] waddr_o,
  output logic [ENT_W-1:0] wdata_o
);
  chan_e            comp_q;
  logic [IDX_W-1:0] idx_q;
  logic [CH_W-1:0]  red_q, grn_q;
  logic             idx_wr, dat_wr;

  assign idx_wr = wr_en_i && (port_e'(wr_sel_i) == PORT_INDEX);
  assign dat_wr = wr_en_i && (port_e'(wr_sel_i) == PORT_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      comp_q <= CH_RED;
      idx_q  <= '0;
      red_q  <= '0;
      grn_q  <= '0;
    end else if (idx_wr) begin
      idx_q  <= IDX_W'(wr_data_i);
      comp_q <= CH_RED;
    end else if (dat_wr) begin
      unique case (comp_q)
        CH_RED: begin
          red_q  <= wr_data_i;
          comp_q <= CH_GREEN;
        end
        CH_GREEN: begin
          grn_q  <= wr_data_i;
          comp_q <= CH_BLUE;
        end
        default: begin
          idx_q  <= idx_q + 1'b1;
          comp_q <= CH_RED;
        end
      endcase
    end
  end

  // commit whole entry on the blue byte
  assign we_o    = dat_wr && (comp_q == CH_BLUE);
  assign waddr_o = idx_q;
  assign wdata_o = {red_q, grn_q, wr_data_i};
  assign comp_o  = comp_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/pal_rd_addr.sv
module pal_rd_addr
  import pal_lut_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CH_W  = 8,
  localparam int unsigned ENT_W = NUM_CH * CH_W
) (
  input  logic                    mode_i,
  input  logic [ENT_W-1:0]        pix_i,
  output logic [NUM_CH*IDX_W-1:0] raddr_o
);
  // channel c: 0 red, 1 green, 2 blue; blue sits in the low byte
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned LSB = (NUM_CH - 1 - c) * CH_W;
    always_comb begin
      if (lk_mode_e'(mode_i) == LK_GAMMA)
        raddr_o[c*IDX_W +: IDX_W] = IDX_W'(pix_i[LSB +: CH_W]);
      else
        raddr_o[c*IDX_W +: IDX_W] = pix_i[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/pal_bank.sv
module pal_bank #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read-before-write: collision returns stored value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/pal_lut.sv
module pal_lut
  import pal_lut_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CH_W  = 8,
  localparam int unsigned ENT_W = NUM_CH * CH_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [CH_W-1:0]  wr_data_i,
  input  logic             lk_en_i,
  input  logic             lk_mode_i,
  input  logic [ENT_W-1:0] lk_pix_i,
  output logic [ENT_W-1:0] lk_rgb_o
);
  logic [1:0]              comp;
  logic [IDX_W-1:0]        idx;
  logic                    ram_we;
  logic [IDX_W-1:0]        ram_waddr;
  logic [ENT_W-1:0]        ram_wdata;
  logic [NUM_CH*IDX_W-1:0] ram_raddr;

  pal_wr_seq #(.IDX_W(IDX_W), .CH_W(CH_W)) u_seq (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .comp_o (comp),
    .idx_o  (idx),
    .we_o   (ram_we),
    .waddr_o(ram_waddr),
    .wdata_o(ram_wdata)
  );

  pal_rd_addr #(.IDX_W(IDX_W), .CH_W(CH_W)) u_rda (
    .mode_i (lk_mode_i),
    .pix_i  (lk_pix_i),
    .raddr_o(ram_raddr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
    localparam int unsigned LSB = (NUM_CH - 1 - c) * CH_W;
    pal_bank #(.AW(IDX_W), .DW(CH_W)) u_bank (
      .clk_i, .rst_ni,
      .we_i   (ram_we),
      .waddr_i(ram_waddr),
      .wdata_i(ram_wdata[LSB +: CH_W]),
      .re_i   (lk_en_i),
      .raddr_i(ram_raddr[c*IDX_W +: IDX_W]),
      .rdata_o(lk_rgb_o[LSB +: CH_W])
    );
  end
endmodule

// File: rtl/pal_lut_chk.sv
module pal_lut_chk #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CH_W  = 8,
  parameter int unsigned NCH   = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic                 wr_sel_i,
  input logic [CH_W-1:0]      wr_data_i,
  input logic                 lk_en_i,
  input logic                 lk_mode_i,
  input logic [NCH*CH_W-1:0]  lk_rgb_o,
  input logic [1:0]           comp,
  input logic [IDX_W-1:0]     idx,
  input logic                 ram_we,
  input logic [IDX_W-1:0]     ram_waddr,
  input logic [NCH*IDX_W-1:0] ram_raddr
);
  p_idx_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=> (comp == 2'd0 && idx == IDX_W'($past(wr_data_i))));

  p_comp_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp != 2'd3);

  p_single_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |=> (comp == 2'd0));

  p_step_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |=> idx == IDX_W'($past(ram_waddr) + 1'b1));

  p_pal_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_mode_i |-> (ram_raddr[0 +: IDX_W] == ram_raddr[IDX_W +: IDX_W]
                    && ram_raddr[IDX_W +: IDX_W] == ram_raddr[2*IDX_W +: IDX_W]));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(comp) && $stable(idx)));

  p_idle_no_commit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> !ram_we);

  p_out_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_en_i |=> $stable(lk_rgb_o));
endmodule

bind pal_lut pal_lut_chk #(.IDX_W(IDX_W), .CH_W(CH_W), .NCH(pal_lut_pkg::NUM_CH)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .lk_en_i, .lk_mode_i, .lk_rgb_o,
  .comp, .idx, .ram_we, .ram_waddr, .ram_raddr
);

// File: tb/pal_lut_tb_top.sv
`timescale 1ns/1ps
module pal_lut_tb_top;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        lk_en = 1'b0, lk_mode = 1'b0;
  logic [23:0] lk_pix = '0;
  logic [23:0] lk_rgb;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  logic [7:0] m_r [DEPTH];
  logic [7:0] m_g [DEPTH];
  logic [7:0] m_b [DEPTH];
  logic [7:0] m_idx = '0;
  int         m_comp = 0;
  logic [7:0] m_sr = '0, m_sg = '0;

  always #4 clk = ~clk;

  pal_lut dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .lk_en_i(lk_en), .lk_mode_i(lk_mode), .lk_pix_i(lk_pix), .lk_rgb_o(lk_rgb)
  );

  function automatic logic [23:0] exp_rgb(logic mode, logic [23:0] pix);
    if (mode) return {m_r[pix[23:16]], m_g[pix[15:8]], m_b[pix[7:0]]};
    return {m_r[pix[7:0]], m_g[pix[7:0]], m_b[pix[7:0]]};
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_wr(logic sel, logic [7:0] d);
    if (!sel) begin
      m_idx = d; m_comp = 0;
    end else if (m_comp == 0) begin
      m_sr = d; m_comp = 1;
    end else if (m_comp == 1) begin
      m_sg = d; m_comp = 2;
    end else begin
      m_r[m_idx] = m_sr; m_g[m_idx] = m_sg; m_b[m_idx] = d;
      m_idx = m_idx + 8'd1; m_comp = 0;
    end
  endtask

  task automatic host_wr(logic sel, logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(sel, d);
  endtask

  task automatic look(string req, logic mode, logic [23:0] pix);
    logic [23:0] e;
    e = exp_rgb(mode, pix);
    lk_en = 1'b1; lk_mode = mode; lk_pix = pix;
    @(negedge clk);
    lk_en = 1'b0;
    check(req, lk_rgb, e);
  endtask

  task automatic idle_garbage(int n);
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b0; wr_sel = 1'($urandom); wr_data = 8'($urandom);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [23:0] e, hold;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 reset output", lk_rgb, 24'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 output after release", lk_rgb, 24'h0);

    // R1: triplet with no index write lands in entry 0
    host_wr(1'b1, 8'hA1); host_wr(1'b1, 8'hB2); host_wr(1'b1, 8'hC3);
    look("R1 default entry 0", 1'b0, 24'h0);
    check("R1 entry 0 value", lk_rgb, 24'hA1B2C3);

    // fill whole table, pointer wraps back to 0 (R4)
    host_wr(1'b0, 8'h00);
    for (int i = 0; i < 3 * DEPTH; i++) host_wr(1'b1, 8'($urandom));
    look("R4 entry 0 after fill", 1'b0, 24'h0);
    look("R4 entry 255 after fill", 1'b0, 24'hFF);
    host_wr(1'b1, 8'h11); host_wr(1'b1, 8'h22); host_wr(1'b1, 8'h33);
    look("R4 wrap continues at 0", 1'b0, 24'h0);
    check("R4 entry 0 direct", lk_rgb, 24'h112233);

    // R4 explicit wrap 255 -> 0
    host_wr(1'b0, 8'hFF);
    host_wr(1'b1, 8'h01); host_wr(1'b1, 8'h02); host_wr(1'b1, 8'h03);
    host_wr(1'b1, 8'h04); host_wr(1'b1, 8'h05); host_wr(1'b1, 8'h06);
    look("R4 entry 255", 1'b0, 24'hFF);
    look("R4 wrapped entry 0", 1'b0, 24'h00);
    check("R4 wrapped value", lk_rgb, 24'h040506);

    // R2: index load
    host_wr(1'b0, 8'h40);
    host_wr(1'b1, 8'h9A); host_wr(1'b1, 8'h9B); host_wr(1'b1, 8'h9C);
    look("R2 indexed entry", 1'b0, 24'h40);
    check("R2 indexed value", lk_rgb, 24'h9A9B9C);

    // R3: partial triplet leaves entry untouched
    host_wr(1'b0, 8'h20);
    e = exp_rgb(1'b0, 24'h20);
    host_wr(1'b1, 8'h5A); host_wr(1'b1, 8'h5B);
    look("R3 unchanged before blue", 1'b0, 24'h20);
    check("R3 old value held", lk_rgb, e);
    host_wr(1'b1, 8'h5C);
    look("R3 committed", 1'b0, 24'h20);
    check("R3 component order", lk_rgb, 24'h5A5B5C);

    // R7: collision returns old value
    host_wr(1'b0, 8'h33);
    host_wr(1'b1, 8'hE1); host_wr(1'b1, 8'hE2);
    e = exp_rgb(1'b0, 24'h33);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'hE3;
    lk_en = 1'b1; lk_mode = 1'b0; lk_pix = 24'h33;
    @(negedge clk);
    wr_en = 1'b0; lk_en = 1'b0;
    model_wr(1'b1, 8'hE3);
    check("R7 read during write old", lk_rgb, e);
    look("R7 new value next", 1'b0, 24'h33);

    // R8: index write mid-triplet discards staging
    host_wr(1'b0, 8'h05);
    e = exp_rgb(1'b0, 24'h05);
    host_wr(1'b1, 8'h77); host_wr(1'b1, 8'h78);
    host_wr(1'b0, 8'h09);
    host_wr(1'b1, 8'h61); host_wr(1'b1, 8'h62); host_wr(1'b1, 8'h63);
    look("R8 abandoned entry", 1'b0, 24'h05);
    check("R8 abandoned value", lk_rgb, e);
    look("R8 new target", 1'b0, 24'h09);
    check("R8 new target value", lk_rgb, 24'h616263);

    // R9: idle bus activity is ignored
    host_wr(1'b0, 8'h50);
    host_wr(1'b1, 8'hD1);
    idle_garbage(6);
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
    @(negedge clk);
    host_wr(1'b1, 8'hD2); host_wr(1'b1, 8'hD3);
    look("R9 triplet survives idle", 1'b0, 24'h50);
    check("R9 value", lk_rgb, 24'hD1D2D3);
    look("R9 entry 0 untouched", 1'b0, 24'h00);

    // R5: upper bits ignored in palette mode
    look("R5 upper bits ignored", 1'b0, 24'hABCD40);
    check("R5 value", lk_rgb, 24'h9A9B9C);

    // R6: gamma per channel
    look("R6 gamma split", 1'b1, 24'h400920);
    check("R6 value", lk_rgb, {8'h9A, 8'h62, 8'h5C});

    // R10: output holds while disabled
    look("R10 setup", 1'b1, 24'h123456);
    hold = lk_rgb;
    for (int i = 0; i < 4; i++) begin
      lk_pix = 24'($urandom); lk_mode = 1'($urandom);
      @(negedge clk);
      check("R10 hold", lk_rgb, hold);
    end

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom % 10);
      if (op == 0) host_wr(1'b0, 8'($urandom));
      else if (op <= 5) host_wr(1'b1, 8'($urandom));
      else if (op == 6) look("R5 random palette", 1'b0, 24'($urandom));
      else if (op <= 8) look("R6 random gamma", 1'b1, 24'($urandom));
      else idle_garbage(1);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule